// File: doc/BRIEF.md
# Counter Channel Interrupt Hub

This block gathers the event pulses of eight counter channels into one host interrupt and exposes the result through a small byte-wide register window. Each channel's pulse comes from whatever flag source that channel has selected. A pulse only matters when that channel's bit in the interrupt-enable register is set. It then latches a sticky status bit. The host reads the status byte to learn which channels fired.

A channel operation register serves three purposes. One bit holds every counter in reset. A second bit switches the interrupt function on or off. Any write to this register, whatever its value, drops all pending status bits. The interrupt request line is high while any status bit is pending and the interrupt function is on.

Two read paths sit beside the interrupt logic. One returns the raw index-input level of each channel. The other returns differential cable health, with fault detection armed per channel by writing zeros.

Top module: `evt_irq_hub`

## Requirements
- R1: After a cycle with `rst_n` low, the following hold. Status is 0x00, the enable register is 0x00 and the operation register reads 0x00. Cable status (0x17) reads 0xFF. `irq` and `cnt_reset` are low.
- R2: A pulse on `evt_pulse[n]` in a cycle where enable bit n is set makes status bit n read as 1 at offset 0x10 after the next clock edge. The bit stays set until it is cleared.
- R3: A pulse on a channel whose enable bit is 0 leaves that channel's status bit at 0.
- R4: A write to offset 0x11 clears every status bit at the next edge, whatever data is written.
- R5: A qualified event in the same cycle as a write to 0x11 is kept, so its status bit reads 1 after that edge.
- R6: `irq` is 1 exactly when the status byte is nonzero and operation bit 2 is 1.
- R7: Offset 0x11 holds two bits. Bit 0 drives `cnt_reset` (1 holds all counters in reset, 0 lets them run) and bit 2 enables the interrupt function. A read returns these two bits with all other bits 0.
- R8: Offset 0x12 is the enable register, one bit per channel. It can be written and read back.
- R9: A read of offset 0x16 returns `index_lvl` as it is in that cycle.
- R10: A write to offset 0x17 stores one detection-enable bit per channel, where 0 arms detection. A read of 0x17 returns 0 in bit n only when detection is armed for channel n and `cable_ok[n]` is 0.
- R11: Writes to 0x10 and 0x16 change nothing. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 8 | Per-channel event pulses |
| index_lvl | input | 8 | Raw index input levels |
| cable_ok | input | 8 | Differential receiver health, 1 = good |
| irq | output | 1 | Interrupt request to host |
| cnt_reset | output | 1 | Global counter reset level |

## Verification
The bench fires events on channels that are not enabled. A design that ignored the enable mask would show stray status bits there. It also issues a clearing write in the same cycle as a new qualified event. A design that let the clear win would lose that interrupt. Further cases are writes to the read-only status and index offsets, and clearing writes whose data has the enable bit low. Cable readback is checked with detection armed on only part of the channels, so an inverted or unmasked fault path shows up in the wrong bits.

// File: rtl/evt_irq_pkg.sv
// Package: shared widths and register offsets of the interrupt hub.
// Assumes one status bit per channel fits in one data byte.
package evt_irq_pkg;
    localparam int DATA_W = 8;
    localparam int NUM_CH = DATA_W;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_OPER   = 5'h11;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h12;
    localparam logic [ADDR_W-1:0] OFS_INDEX  = 5'h16;
    localparam logic [ADDR_W-1:0] OFS_CABLE  = 5'h17;

    localparam int OP_RESET_BIT = 0;
    localparam int OP_IRQEN_BIT = 2;
endpackage

// File: rtl/evt_status_bank.sv
// Sticky per-channel pending bits.
// A qualified event sets its bit. A clear strobe drops all bits, but an
// event in the clearing cycle still lands. Assumes clr is one cycle wide per write.
module evt_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    output logic [W-1:0] status
);
    logic [W-1:0] qual;

    // Mask raw events with the per-channel enables.
    always_comb qual = evt & en;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Hold, clear or set one channel's pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[g] <= 1'b0;
            else
                status[g] <= (status[g] & ~clr) | qual[g];
        end
    end

    // R3: a bit may only become set where a qualified event was seen.
    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt & en)) == '0));

    // R4: a clear with no qualified event leaves nothing pending.
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ((evt & en) == '0)) |=> (status == '0));

    // R5: qualified events are always captured, even during a clear.
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & en) != '0) |=> ((status & $past(evt & en)) == $past(evt & en)));
endmodule

// File: rtl/chan_op_reg.sv
// Channel operation register: the global counter-reset bit and the
// interrupt-function enable bit. Assumes wr is already decoded for its offset.
module chan_op_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wd_reset,
    input  logic wd_irqen,
    output logic cnt_reset,
    output logic irq_fn_en
);
    // Capture both control bits on a write to the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_reset <= 1'b0;
            irq_fn_en <= 1'b0;
        end else if (wr) begin
            cnt_reset <= wd_reset;
            irq_fn_en <= wd_irqen;
        end
    end

    // R7: the reset level follows the written bit.
    p_opwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_reset == $past(wd_reset)) && (irq_fn_en == $past(wd_irqen)));

    // R7: both bits hold when there is no write.
    p_ophold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cnt_reset) && $stable(irq_fn_en));
endmodule

// File: rtl/cable_fault_mon.sv
// Per-channel cable fault detection arming and the readback value.
// Stored bit 0 arms detection. A readback bit of 0 reports a fault on an
// armed channel. Assumes cable_ok comes from already synchronised receiver status.
module cable_fault_mon #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cable_ok,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] det_off;

    // Store the arming mask; reset leaves every channel disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            det_off <= '1;
        else if (wr)
            det_off <= wdata;
    end

    // A channel reads good unless armed and its receiver reports a fault.
    always_comb rd_val = cable_ok | det_off;

    // R10: the arming mask takes the written byte.
    p_cablewr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (det_off == $past(wdata)));

    // R10: a healthy cable never reads as faulted.
    p_nofalse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_val | ~cable_ok) == '1));
endmodule

// File: rtl/hub_read_mux.sv
// Combinational read-data selection for the register window.
// Unmapped offsets read as zero. Assumes no read side effects.
module hub_read_mux
    import evt_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] status,
    input  logic              op_reset,
    input  logic              op_irqen,
    input  logic [NUM_CH-1:0] enable,
    input  logic [NUM_CH-1:0] index_lvl,
    input  logic [NUM_CH-1:0] cable_val,
    output logic [DATA_W-1:0] rdata
);
    // Pick the register image addressed by the host.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_STATUS: rdata = status;
            OFS_OPER: begin
                rdata[OP_RESET_BIT] = op_reset;
                rdata[OP_IRQEN_BIT] = op_irqen;
            end
            OFS_ENABLE: rdata = enable;
            OFS_INDEX:  rdata = index_lvl;
            OFS_CABLE:  rdata = cable_val;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_hub.sv
// Top of the counter interrupt hub. It decodes byte writes to the register
// window, keeps the enable mask, and joins the status bank, the operation
// register, the cable monitor and the read mux. Assumes one bus access per
// cycle and inputs already synchronous to clk.
module evt_irq_hub
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] evt_pulse,
    input  logic [NUM_CH-1:0] index_lvl,
    input  logic [NUM_CH-1:0] cable_ok,
    output logic              irq,
    output logic              cnt_reset
);
    logic              wr_oper, wr_enable, wr_cable;
    logic [NUM_CH-1:0] enable_q;
    logic [NUM_CH-1:0] status;
    logic              irq_fn_en;
    logic [NUM_CH-1:0] cable_val;

    // Decode one write strobe per writable register.
    always_comb begin
        wr_oper   = bus_we && (bus_addr == OFS_OPER);
        wr_enable = bus_we && (bus_addr == OFS_ENABLE);
        wr_cable  = bus_we && (bus_addr == OFS_CABLE);
    end

    // Per-channel interrupt enable mask, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (wr_enable)
            enable_q <= bus_wdata;
    end

    evt_status_bank #(.W(NUM_CH)) status_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_oper),
        .evt    (evt_pulse),
        .en     (enable_q),
        .status (status)
    );

    chan_op_reg oper_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_oper),
        .wd_reset  (bus_wdata[OP_RESET_BIT]),
        .wd_irqen  (bus_wdata[OP_IRQEN_BIT]),
        .cnt_reset (cnt_reset),
        .irq_fn_en (irq_fn_en)
    );

    cable_fault_mon #(.W(NUM_CH)) cable_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cable),
        .wdata    (bus_wdata),
        .cable_ok (cable_ok),
        .rd_val   (cable_val)
    );

    hub_read_mux rmux_i (
        .addr      (bus_addr),
        .status    (status),
        .op_reset  (cnt_reset),
        .op_irqen  (irq_fn_en),
        .enable    (enable_q),
        .index_lvl (index_lvl),
        .cable_val (cable_val),
        .rdata     (bus_rdata)
    );

    // Raise the request while anything is pending and the function is on.
    always_comb irq = irq_fn_en && (status != '0);

    // R8: the enable mask takes the written byte.
    p_enwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable_q == $past(bus_wdata)));

    // R6: a request needs a pending channel at the status port.
    p_irqsrc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && bus_addr == OFS_STATUS) |-> (bus_rdata != '0));
endmodule

// File: tb/evt_irq_hub_tb_top.sv
`timescale 1ns/1ps
module evt_irq_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = 5'h10;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] evt_pulse = 8'h00;
    logic [7:0] index_lvl = 8'h00;
    logic [7:0] cable_ok = 8'hFF;
    logic       irq, cnt_reset;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // Behavioural reference state.
    bit [7:0] m_st, m_en, m_det;
    bit       m_rst, m_fn;

    always #2.5 clk = ~clk;

    evt_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .index_lvl(index_lvl), .cable_ok(cable_ok), .irq(irq), .cnt_reset(cnt_reset)
    );

    function automatic bit [7:0] exp_rd();
        case (bus_addr)
            5'h10: return m_st;
            5'h11: return {5'b0, m_fn, 1'b0, m_rst};
            5'h12: return m_en;
            5'h16: return index_lvl;
            5'h17: return cable_ok | m_det;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare after the edge.
    task automatic cyc(bit we, bit [4:0] a, bit [7:0] wd, bit [7:0] ev);
        bus_we = we; bus_addr = a; bus_wdata = wd; evt_pulse = ev;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_det = 8'hFF; m_rst = 0; m_fn = 0;
        end else begin
            bit [7:0] q;
            q = ev & m_en;
            m_st = ((we && a == 5'h11) ? 8'h00 : m_st) | q;
            if (we && a == 5'h12) m_en = wd;
            if (we && a == 5'h11) begin m_rst = wd[0]; m_fn = wd[2]; end
            if (we && a == 5'h17) m_det = wd;
        end
        chk("irq", irq, (m_fn && m_st != 0));
        chk("cnt_reset", cnt_reset, m_rst);
        chk($sformatf("rdata@%0h", a), bus_rdata, exp_rd());
        bus_we = 1'b0;
    endtask

    task automatic rd(bit [4:0] a);
        cyc(1'b0, a, 8'h00, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #50000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state on every register.
        tag = "R1";
        rst_n = 1'b0;
        cyc(0, 5'h10, 0, 8'hFF);
        cyc(0, 5'h11, 0, 0);
        rst_n = 1'b1;
        rd(5'h10); rd(5'h11); rd(5'h12); rd(5'h17);

        // R3: events with all enables clear leave status empty.
        tag = "R3";
        cyc(0, 5'h10, 0, 8'hFF);
        cyc(0, 5'h10, 0, 8'h81);
        rd(5'h10);

        // R8: enable register write and readback.
        tag = "R8";
        cyc(1, 5'h12, 8'h5A, 0);
        rd(5'h12);

        // R2: only enabled channels latch, bits are sticky.
        tag = "R2";
        cyc(0, 5'h10, 0, 8'hFF);
        rd(5'h10); rd(5'h10);
        tag = "R3";
        cyc(0, 5'h10, 0, 8'hA5);
        rd(5'h10);

        // R4: clearing write with the enable bit low, irq stays off.
        tag = "R4";
        cyc(1, 5'h11, 8'h00, 0);
        rd(5'h10);

        // R6: interrupt function on, pending event raises irq.
        tag = "R6";
        cyc(1, 5'h11, 8'h04, 0);
        cyc(0, 5'h10, 0, 8'h02);
        rd(5'h10); rd(5'h11);
        cyc(1, 5'h11, 8'h00, 0);
        cyc(0, 5'h10, 0, 8'h08);
        rd(5'h10);
        cyc(1, 5'h11, 8'h04, 0);

        // R5: event in the same cycle as a clearing write survives.
        tag = "R5";
        cyc(0, 5'h10, 0, 8'h10);
        cyc(1, 5'h11, 8'hFB, 8'h08);
        rd(5'h10);
        cyc(1, 5'h11, 8'h04, 8'h42);
        rd(5'h10);

        // R11: writes to read-only offsets do nothing, unmapped reads zero.
        tag = "R11";
        cyc(1, 5'h10, 8'h00, 0);
        rd(5'h10);
        cyc(1, 5'h16, 8'hFF, 0);
        rd(5'h00); rd(5'h13); rd(5'h1F);

        // R7: counter reset bit and readback of the operation register.
        tag = "R7";
        cyc(1, 5'h11, 8'h01, 0);
        rd(5'h11); rd(5'h11);
        cyc(1, 5'h11, 8'hFF, 0);
        rd(5'h11);

        // R9: raw index levels.
        tag = "R9";
        index_lvl = 8'h3C; rd(5'h16);
        index_lvl = 8'hC1; rd(5'h16);

        // R10: cable fault arming on low channels only.
        tag = "R10";
        cable_ok = 8'h00; rd(5'h17);
        cyc(1, 5'h17, 8'hF0, 0);
        rd(5'h17);
        cable_ok = 8'h96; rd(5'h17);
        cyc(1, 5'h17, 8'h00, 0);
        rd(5'h17);

        // R1: reset again after activity.
        tag = "R1";
        rst_n = 1'b0;
        cyc(0, 5'h10, 0, 0);
        rst_n = 1'b1;
        rd(5'h10); rd(5'h12); rd(5'h17); rd(5'h11);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule